// File: doc/BRIEF.md
# Two-Colour Matrix Chain Loader

This block drives a daisy chain of three 8-bit serial-in/parallel-out shift registers that run a two-colour 8×8 LED matrix. The register nearest the block holds the green column drives. The middle register holds the red column drives. The register at the far end of the chain selects the row. Rows are scanned one at a time, in a loop that never stops. For each row the block sends one 24-bit word on a serial data pin, using a shift clock at half the system clock. Data changes only while the shift clock is low, so every rising edge samples data that has been stable for a full system cycle. Once the word is complete, the block pulses a storage clock, and the chain moves the new bits to its outputs all together. The outputs therefore never show partial data while shifting is in progress.

Picture contents enter through a plain write port. Each write replaces the red and green column bytes of one row, and every write is accepted with no stall. For that reason the port has no ready signal. Brightness is set apart from the picture data. A free-running counter compares against a level input and drives the chain's active-low output-enable pin, which dims every LED of the panel together.

One row takes 2×24+4 system cycles: 48 for shifting, 2 idle cycles, and 2 cycles of storage pulse. A full picture takes that count multiplied by the number of rows.

Top module: `matrix_chain_loader`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, the shift clock, storage clock and serial data are 0 and the output-enable is 1 (LEDs dark).
- R2: The shift clock runs at half the system clock. Each row starts with a low cycle and has exactly 24 rising edges, on system cycles 1, 3, …, 47 of the row (cycle 0 is the row's first cycle).
- R3: Serial data changes only on the system edge where the shift clock goes low, so it is held through every high cycle of the shift clock.
- R4: The row word is {row select, red, green} and is sent most significant bit first. After the storage pulse, bit r of the far register is 1 only for row r, bit c of the middle register is the red bit of column c, and bit c of the near register is the green bit of column c.
- R5: After the last high cycle of the shift clock come 2 cycles with all lines low. The storage clock is then high for exactly 2 cycles, and the shift clock never goes high while the storage clock is high.
- R6: Rows are scanned in the order 0, 1, …, ROWS-1, then back to 0. Each row lasts 2·24+4 system cycles, and scanning begins with row 0 directly after reset.
- R7: A row's word is read from the frame store on the edge where the previous row's storage pulse enters its second cycle. A write landing on that edge or later appears at the next scan of that row. The first row after reset carries blank colour data.
- R8: A write with wr_en high stores wr_red and wr_green into row wr_row on that clock edge. The frame store resets to all zero.
- R9: A PWM_BITS-wide counter runs freely from 0 after reset. Each cycle the output-enable is low when the counter value before the edge is below dim_level, and high otherwise. A level of 0 keeps the LEDs dark at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Frame write strobe |
| wr_row | input | ROW_AW | Row index of the write |
| wr_red | input | REG_W | Red column bits, bit c for column c |
| wr_green | input | REG_W | Green column bits, bit c for column c |
| dim_level | input | PWM_BITS | On-time per PWM period, in cycles |
| sr_data | output | 1 | Serial data into the chain |
| sr_clk | output | 1 | Shift clock of the chain |
| sr_latch | output | 1 | Storage clock of the chain |
| sr_oe_n | output | 1 | Active-low output enable of the chain |

## Verification
The bench builds the block with ROWS=4, REG_W=8 and PWM_BITS=3. A full picture then takes only 208 cycles and a PWM period only 8 cycles, so one run covers many wraps of the row scan and the dimming counter. This includes writes that land exactly on the edge where a row word is read, the zero level, and the full level. A behavioural model of the three-register chain collects the shifted bits and compares them with each stored row, while a second model predicts every pin on every cycle.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
  // Phase of a row slot, derived from the position counter
  typedef enum logic [1:0] {
    PH_SHIFT = 2'd0,
    PH_GAP   = 2'd1,
    PH_STORE = 2'd2
  } mcl_phase_e;

  // Number of chained registers: row select, red plane, green plane
  localparam int STAGES = 3;
  // Idle cycles between last shift and storage pulse, and pulse length
  localparam int GAP_CYC   = 2;
  localparam int STORE_CYC = 2;
endpackage

// File: rtl/mcl_frame_store.sv
module mcl_frame_store #(
  parameter int ROWS   = 8,
  parameter int REG_W  = 8,
  parameter int ROW_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_AW-1:0] wr_row,
  input  logic [REG_W-1:0]  wr_red,
  input  logic [REG_W-1:0]  wr_green,
  input  logic [ROW_AW-1:0] rd_row,
  output logic [REG_W-1:0]  rd_red,
  output logic [REG_W-1:0]  rd_green
);
  logic [REG_W-1:0] red_q [ROWS];
  logic [REG_W-1:0] grn_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        red_q[r] <= '0;
        grn_q[r] <= '0;
      end else if (wr_en && (wr_row == ROW_AW'(r))) begin
        red_q[r] <= wr_red;
        grn_q[r] <= wr_green;
      end
    end

    // R8: a write to this row is visible on the next cycle
    assert_store_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_row == ROW_AW'(r))) |=>
        (red_q[r] == $past(wr_red)) && (grn_q[r] == $past(wr_green)));
  end

  assign rd_red   = red_q[rd_row];
  assign rd_green = grn_q[rd_row];
endmodule

// File: rtl/mcl_oe_pwm.sv
module mcl_oe_pwm #(
  parameter int PWM_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PWM_BITS-1:0] level,
  output logic                oe_n
);
  logic [PWM_BITS-1:0] cnt_q;
  logic                oe_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      oe_n_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      oe_n_q <= !(cnt_q < level);
    end
  end

  assign oe_n = oe_n_q;

  // R9: zero level keeps the panel dark
  assert_dark_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |=> oe_n_q);
  // R9: any non-zero level lights the panel at the start of a period
  assert_on_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && (level != '0)) |=> !oe_n_q);
endmodule

// File: rtl/mcl_row_shifter.sv
module mcl_row_shifter
  import mcl_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int REG_W  = 8,
  parameter int ROW_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ROW_AW-1:0] rd_row,
  input  logic [REG_W-1:0]  rd_red,
  input  logic [REG_W-1:0]  rd_green,
  output logic              sdata,
  output logic              sclk,
  output logic              latch
);
  localparam int WORD_W    = STAGES * REG_W;
  localparam int SHIFT_LEN = 2 * WORD_W;
  localparam int PERIOD    = SHIFT_LEN + GAP_CYC + STORE_CYC;
  localparam int POS_W     = $clog2(PERIOD);
  localparam int GAP_END   = SHIFT_LEN + GAP_CYC;

  logic [POS_W-1:0]  pos_q;
  logic [ROW_AW-1:0] row_q;
  logic [WORD_W-1:0] snap_q;
  logic              sdata_q, sclk_q, latch_q;

  mcl_phase_e        phase;
  logic [ROW_AW-1:0] next_row;
  logic [REG_W-1:0]  next_sel;
  logic [WORD_W-1:0] next_word;
  logic              row_end;

  always_comb begin
    if (pos_q < POS_W'(SHIFT_LEN))    phase = PH_SHIFT;
    else if (pos_q < POS_W'(GAP_END)) phase = PH_GAP;
    else                              phase = PH_STORE;
  end

  assign row_end  = (pos_q == POS_W'(PERIOD - 1));
  assign next_row = (row_q == ROW_AW'(ROWS - 1)) ? '0 : row_q + 1'b1;
  assign rd_row   = next_row;

  always_comb begin
    next_sel           = '0;
    next_sel[next_row] = 1'b1;
    next_word          = {next_sel, rd_red, rd_green};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      row_q   <= '0;
      snap_q  <= {{(REG_W-1){1'b0}}, 1'b1, {(2*REG_W){1'b0}}};
      sdata_q <= 1'b0;
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      unique case (phase)
        PH_SHIFT: begin
          sclk_q  <= pos_q[0];
          sdata_q <= snap_q[WORD_W-1];
          latch_q <= 1'b0;
          if (pos_q[0]) snap_q <= {snap_q[WORD_W-2:0], 1'b0};
        end
        PH_GAP: begin
          sclk_q  <= 1'b0;
          sdata_q <= 1'b0;
          latch_q <= 1'b0;
        end
        default: begin
          sclk_q  <= 1'b0;
          sdata_q <= 1'b0;
          latch_q <= 1'b1;
        end
      endcase
      if (row_end) begin
        pos_q  <= '0;
        row_q  <= next_row;
        snap_q <= next_word;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign sdata = sdata_q;
  assign sclk  = sclk_q;
  assign latch = latch_q;

  // R3: data held through every high phase of the shift clock
  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(sdata_q));
  // R5: storage clock and shift clock never high together
  assert_latch_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_q && sclk_q));
  // R5: storage pulse lasts exactly two cycles
  assert_latch_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |=> latch_q);
  assert_latch_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && $past(latch_q)) |=> !latch_q);
  // R2: shift clock alternates, never high two cycles running
  assert_sclk_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |=> !sclk_q);
endmodule

// File: rtl/matrix_chain_loader.sv
module matrix_chain_loader #(
  parameter int ROWS     = 8,
  parameter int REG_W    = 8,
  parameter int PWM_BITS = 4,
  localparam int ROW_AW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ROW_AW-1:0]   wr_row,
  input  logic [REG_W-1:0]    wr_red,
  input  logic [REG_W-1:0]    wr_green,
  input  logic [PWM_BITS-1:0] dim_level,
  output logic                sr_data,
  output logic                sr_clk,
  output logic                sr_latch,
  output logic                sr_oe_n
);
  logic [ROW_AW-1:0] rd_row;
  logic [REG_W-1:0]  rd_red, rd_green;

  mcl_frame_store #(.ROWS(ROWS), .REG_W(REG_W), .ROW_AW(ROW_AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_row   (wr_row),
    .wr_red   (wr_red),
    .wr_green (wr_green),
    .rd_row   (rd_row),
    .rd_red   (rd_red),
    .rd_green (rd_green)
  );

  mcl_row_shifter #(.ROWS(ROWS), .REG_W(REG_W), .ROW_AW(ROW_AW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_row   (rd_row),
    .rd_red   (rd_red),
    .rd_green (rd_green),
    .sdata    (sr_data),
    .sclk     (sr_clk),
    .latch    (sr_latch)
  );

  mcl_oe_pwm #(.PWM_BITS(PWM_BITS)) u_pwm (
    .clk   (clk),
    .rst_n (rst_n),
    .level (dim_level),
    .oe_n  (sr_oe_n)
  );
endmodule

// File: tb/tb_matrix_chain_loader.sv
module tb_matrix_chain_loader;
  localparam int ROWS     = 4;
  localparam int REG_W    = 8;
  localparam int PWM_BITS = 3;
  localparam int ROW_AW   = 2;
  localparam int WORD_W   = 3 * REG_W;
  localparam int SHIFT_LEN = 2 * WORD_W;
  localparam int PERIOD   = SHIFT_LEN + 4;
  localparam int PWM_P    = 1 << PWM_BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ROW_AW-1:0] wr_row = '0;
  logic [REG_W-1:0] wr_red = '0, wr_green = '0;
  logic [PWM_BITS-1:0] dim_level = '0;
  logic sr_data, sr_clk, sr_latch, sr_oe_n;

  always #4 clk = ~clk;

  matrix_chain_loader #(.ROWS(ROWS), .REG_W(REG_W), .PWM_BITS(PWM_BITS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_red(wr_red), .wr_green(wr_green), .dim_level(dim_level),
    .sr_data(sr_data), .sr_clk(sr_clk), .sr_latch(sr_latch), .sr_oe_n(sr_oe_n)
  );

  int checks = 0;
  int errors = 0;
  int latches = 0;
  bit done = 1'b0;

  // Reference model state
  int n = 0;
  bit model_on = 1'b0;
  logic [REG_W-1:0] sh_red [ROWS];
  logic [REG_W-1:0] sh_grn [ROWS];
  logic [WORD_W-1:0] cur_word;
  logic exp_clk = 1'b0, exp_latch = 1'b0, exp_data = 1'b0, exp_oe = 1'b1;

  function automatic logic [WORD_W-1:0] mk_word(int r, logic [REG_W-1:0] rd,
                                                 logic [REG_W-1:0] gn);
    logic [REG_W-1:0] sel;
    sel = '0;
    sel[r] = 1'b1;
    return {sel, rd, gn};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0;
      for (int i = 0; i < ROWS; i++) begin sh_red[i] = '0; sh_grn[i] = '0; end
      cur_word = mk_word(0, '0, '0);
      exp_clk = 0; exp_latch = 0; exp_data = 0; exp_oe = 1;
    end else begin
      int p, r;
      p = n % PERIOD;
      r = (n / PERIOD) % ROWS;
      if (p < SHIFT_LEN) begin
        exp_clk = p[0]; exp_latch = 0; exp_data = cur_word[WORD_W-1-p/2];
      end else if (p < SHIFT_LEN + 2) begin
        exp_clk = 0; exp_latch = 0; exp_data = 0;
      end else begin
        exp_clk = 0; exp_latch = 1; exp_data = 0;
      end
      exp_oe = !((n % PWM_P) < int'(dim_level));
      if (p == PERIOD - 1)
        cur_word = mk_word((r + 1) % ROWS, sh_red[(r+1)%ROWS], sh_grn[(r+1)%ROWS]);
      if (wr_en) begin sh_red[wr_row] = wr_red; sh_grn[wr_row] = wr_green; end
      n++;
    end
  end

  // Behavioural three-register chain
  logic [WORD_W-1:0] chain = '0;
  always @(posedge sr_clk) chain = {chain[WORD_W-2:0], sr_data};
  always @(posedge sr_latch) begin
    if (model_on) begin
      checks++;
      latches++;
      if (chain !== cur_word) begin
        errors++;
        $display("FAIL R4/R6/R7/R8 stored row: actual %h expected %h", chain, cur_word);
      end
    end
  end

  // Per-cycle pin comparison away from the active edge
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      checks++;
      if (sr_clk !== exp_clk) begin
        errors++;
        $display("FAIL R2 shift clock at n=%0d: actual %b expected %b", n, sr_clk, exp_clk);
      end
      if (sr_latch !== exp_latch) begin
        errors++;
        $display("FAIL R5 storage clock at n=%0d: actual %b expected %b", n, sr_latch, exp_latch);
      end
      if (sr_data !== exp_data) begin
        errors++;
        $display("FAIL R3/R4 serial data at n=%0d: actual %b expected %b", n, sr_data, exp_data);
      end
      if (sr_oe_n !== exp_oe) begin
        errors++;
        $display("FAIL R9 output enable at n=%0d: actual %b expected %b", n, sr_oe_n, exp_oe);
      end
    end
  end

  task automatic wait_cycles(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic write_row(int r, logic [REG_W-1:0] rd, logic [REG_W-1:0] gn);
    wr_en = 1'b1; wr_row = ROW_AW'(r); wr_red = rd; wr_green = gn;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    wait_cycles(5);
    // R1: reset state of every pin
    checks++;
    if ({sr_clk, sr_latch, sr_data, sr_oe_n} !== 4'b0001) begin
      errors++;
      $display("FAIL R1 reset pins: actual %b expected 0001",
               {sr_clk, sr_latch, sr_data, sr_oe_n});
    end
    dim_level = 3'd3;
    rst_n = 1'b1;
    model_on = 1'b1;
    // R7: first picture is blank colour with row select only
    wait_cycles(ROWS * PERIOD);
    // R8: fill each row with a distinct pattern
    for (int r = 0; r < ROWS; r++) write_row(r, 8'h81 << r, 8'hF0 >> r);
    wait_cycles(2 * ROWS * PERIOD);
    // R7: writes landing on and around the word-read edge
    for (int off = PERIOD - 3; off < PERIOD + 2; off++) begin
      while (n % PERIOD != off % PERIOD) @(negedge clk);
      write_row((n / PERIOD + 1) % ROWS, 8'($urandom), 8'($urandom));
    end
    // R9: dimming levels including zero and full
    for (int lv = 0; lv < PWM_P; lv++) begin
      dim_level = PWM_BITS'(lv);
      wait_cycles(3 * PWM_P + 1);
    end
    // Random traffic on every input
    for (int i = 0; i < 1500; i++) begin
      wr_en = ($urandom % 3) == 0;
      wr_row = ROW_AW'($urandom);
      wr_red = 8'($urandom);
      wr_green = 8'($urandom);
      if ((i % 37) == 0) dim_level = PWM_BITS'($urandom);
      @(negedge clk);
    end
    wr_en = 1'b0;
    dim_level = '0;
    wait_cycles(2 * ROWS * PERIOD);
    // R6: scanning must have produced many stored rows
    checks++;
    if (latches < 4 * ROWS) begin
      errors++;
      $display("FAIL R6 stored row count: actual %0d expected >= %0d", latches, 4 * ROWS);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule